// File: doc/BRIEF.md
# E1 Doubleframe Alignment Synchronizer

This block takes a serial E1 receive bit stream, one bit per cycle in which `bit_en` is high. It finds the frame alignment word in the first time slot and declares frame synchronization once an acquisition sequence has completed. While in sync it watches the alignment word and the alternate-frame service word, and it drops sync when errors repeat. The alignment word is the seven-bit pattern 0011011, received in time-slot-0 bits 2 to 8. Frames that carry it alternate with frames whose time-slot-0 bit 2 is the service bit, which is 1 when correct, and whose bit 3 carries the remote alarm.

Downstream logic receives several outputs:
- a loss-of-alignment status and a one-cycle loss interrupt,
- a frame-start strobe and the bit position inside the frame,
- a saturating framing-error count,
- the latched remote alarm,
- an AIS-forcing control for the backplane side.

Configuration inputs do four things. One raises the loss threshold from three to four consecutive errors. One turns off loss on service-word errors. One suppresses the AIS forcing. One forces a new alignment search.

Top module: `e1_frame_aligner`

## Requirements
- R1: After reset `lof` is 1, `lof_irq` is 0, `fec` is 0 and `rai` is 0.
- R2: A candidate is a position where the last seven received bits are 0011011, oldest first. These are bits 2 to 8 of time slot 0, and bit 1 is not examined. Sync needs three checks in order: a candidate in frame n, service bit (time-slot-0 bit 2) = 1 in frame n+1, and the alignment word at the same position in frame n+2. `lof` falls after the `bit_en` cycle that carries bit 8 of frame n+2.
- R3: If the service bit of frame n+1 is 0, the search skips ahead. It restarts only after the alignment position of frame n+2, so the word in frame n+2 is not taken as a candidate. If the alignment word of frame n+2 fails, the search restarts at the very next bit.
- R4: In sync, 3 consecutive wrong alignment words set `lof`. When `thr_four` is 1, 4 are needed. A correct word clears the run.
- R5: In sync, 3 consecutive service-word frames with bit 2 = 0 set `lof`, or 4 when `thr_four` is 1.
- R6: When `sw_chk_off` is 1, service-word errors never cause loss of sync.
- R7: `lof_irq` is high for exactly one cycle each time the block leaves sync, and at no other time.
- R8: `fec` increases by one for each wrong alignment word seen while in sync. It is frozen while `lof` is 1 and saturates at all ones. `fec_clr` clears it synchronously.
- R9: In sync, `rai` takes time-slot-0 bit 3 of each service-word frame. While `lof` is 1, `rai` holds its value.
- R10: `ais_on` is 1 while `lof` is 1, unless `ais_dis` is 1.
- R11: `force_resync` puts the block out of sync on the next cycle and starts a new search. Sync then returns after three frames as in R2.
- R12: `bit_pos` is the index, from 0, of the bit that the next `bit_en` will take. `frame_start` is high during the `bit_en` cycle carrying bit 1 of a frame while in sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies `rx_bit` for this cycle |
| rx_bit | input | 1 | Received serial bit |
| thr_four | input | 1 | Loss threshold of 4 instead of 3 |
| sw_chk_off | input | 1 | Service-word errors do not cause loss |
| ais_dis | input | 1 | Suppresses AIS forcing |
| force_resync | input | 1 | Drops sync and restarts the search |
| fec_clr | input | 1 | Clears the framing-error count |
| lof | output | 1 | Out of frame alignment |
| lof_irq | output | 1 | One-cycle pulse on loss of sync |
| ais_on | output | 1 | Force all-ones toward the backplane |
| frame_start | output | 1 | First bit of a frame, in sync |
| bit_pos | output | $clog2(FRAME_BITS) | Index of the next bit in the frame |
| fec | output | FEC_W | Saturating framing-error count |
| rai | output | 1 | Latched remote alarm |

## Verification
The bench builds the block with `FRAME_BITS` = 16 and `FEC_W` = 4. With 16-bit frames a full acquisition and loss sequence costs only a few hundred cycles. This allows a sweep over every combination of threshold, service-check disable and error kind, with each expected loss point worked out arithmetically. The 4-bit counter reaches saturation within a few dozen bad alignment words. The filler bits never form a false alignment word, so the frame in which sync is gained or lost is known exactly.

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner #(
  parameter int FRAME_BITS = 256,
  parameter int FEC_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic rx_bit,
  input  logic thr_four,
  input  logic sw_chk_off,
  input  logic ais_dis,
  input  logic force_resync,
  input  logic fec_clr,
  output logic lof,
  output logic lof_irq,
  output logic ais_on,
  output logic frame_start,
  output logic [$clog2(FRAME_BITS)-1:0] bit_pos,
  output logic [FEC_W-1:0] fec,
  output logic rai
);
  localparam int PW = $clog2(FRAME_BITS);
  localparam logic [6:0] ALIGN = 7'b0011011;

  typedef enum logic [2:0] {HUNT, GOT_FAS, GOT_SW, SKIP, SYNC} st_t;
  st_t st, st_n;

  logic [5:0] sr;
  logic [PW-1:0] pos;
  logic expect_fas;
  logic [2:0] fas_run, sw_run;

  wire [6:0] win = {sr, rx_bit};
  wire word_ok = (win == ALIGN);
  wire sw_bit = win[6];
  wire ra_bit = win[5];
  wire chk = bit_en && (pos == PW'(7));
  wire insync = (st == SYNC);
  wire [2:0] lim = thr_four ? 3'd4 : 3'd3;
  wire fas_bad = chk && insync && expect_fas && !word_ok;
  wire sw_bad = chk && insync && !expect_fas && !sw_bit && !sw_chk_off;
  wire drop = (fas_bad && (fas_run + 3'd1 == lim)) || (sw_bad && (sw_run + 3'd1 == lim));
  wire found = bit_en && (st == HUNT) && word_ok && !force_resync;

  assign lof = !insync;
  assign ais_on = lof && !ais_dis;
  assign frame_start = bit_en && (pos == '0) && insync;
  assign bit_pos = pos;

  always_comb begin
    st_n = st;
    if (force_resync) st_n = HUNT;
    else if (found) st_n = GOT_FAS;
    else if (chk) begin
      case (st)
        GOT_FAS: st_n = sw_bit ? GOT_SW : SKIP;
        SKIP:    st_n = HUNT;
        GOT_SW:  st_n = word_ok ? SYNC : HUNT;
        SYNC:    if (drop) st_n = HUNT;
        default: st_n = st;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT;
      sr <= '0;
      pos <= '0;
      expect_fas <= 1'b0;
      fas_run <= '0;
      sw_run <= '0;
      fec <= '0;
      rai <= 1'b0;
      lof_irq <= 1'b0;
    end else begin
      st <= st_n;
      lof_irq <= insync && (st_n != SYNC);
      if (bit_en) begin
        sr <= win[5:0];
        if (found) pos <= PW'(8 % FRAME_BITS);
        else if (pos == PW'(FRAME_BITS - 1)) pos <= '0;
        else pos <= pos + 1'b1;
      end
      if (chk && st == GOT_SW) expect_fas <= 1'b0;
      else if (chk && insync) expect_fas <= !expect_fas;
      if (st_n != SYNC) begin
        fas_run <= '0;
        sw_run <= '0;
      end else if (chk && insync) begin
        if (expect_fas) fas_run <= word_ok ? 3'd0 : fas_run + 3'd1;
        else sw_run <= (sw_bit || sw_chk_off) ? 3'd0 : sw_run + 3'd1;
      end
      if (fec_clr) fec <= '0;
      else if (fas_bad && fec != '1) fec <= fec + 1'b1;
      if (chk && insync && !expect_fas && !force_resync) rai <= ra_bit;
    end
  end

  // R7
  irq_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lof_irq |-> (lof && !$past(lof)));
  // R7
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lof_irq |=> !lof_irq);
  // R8
  fec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lof) && !$past(fec_clr)) |-> $stable(fec));
  // R8
  fec_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&$past(fec)) && !$past(fec_clr)) |-> (&fec));
  // R9
  rai_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lof) |-> $stable(rai));
  // R11
  force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_resync |=> lof);
endmodule

// File: tb/sim_e1_frame_aligner.sv
module sim_e1_frame_aligner;
  localparam int FB = 16;
  localparam int FW = 4;
  localparam logic [6:0] PAT = 7'b0011011;

  logic clk = 0, rst_n = 0, bit_en = 0, rx_bit = 1;
  logic thr_four = 0, sw_chk_off = 0, ais_dis = 0, force_resync = 0, fec_clr = 0;
  logic lof, lof_irq, ais_on, frame_start, rai;
  logic [$clog2(FB)-1:0] bit_pos;
  logic [FW-1:0] fec;

  int n_chk = 0, n_bad = 0, fs_cnt = 0, irq_cnt = 0;
  logic l6, l7;

  always #10 clk = ~clk;

  e1_frame_aligner #(.FRAME_BITS(FB), .FEC_W(FW)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .thr_four(thr_four), .sw_chk_off(sw_chk_off), .ais_dis(ais_dis),
    .force_resync(force_resync), .fec_clr(fec_clr), .lof(lof), .lof_irq(lof_irq),
    .ais_on(ais_on), .frame_start(frame_start), .bit_pos(bit_pos), .fec(fec), .rai(rai));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; bit_en = 0; force_resync = 0; fec_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send_bit(input logic b, input int idx);
    @(negedge clk);
    rx_bit = b; bit_en = 1;
    #1 fs_cnt += int'(frame_start);
    @(negedge clk);
    bit_en = 0;
    irq_cnt += int'(lof_irq);
    if (idx == 6) l6 = lof;
    if (idx == 7) l7 = lof;
  endtask

  task automatic send_frame(input bit fas, input bit good, input bit swb, input bit ra);
    for (int i = 0; i < FB; i++) begin
      bit b;
      b = 1'b1;
      if (fas) begin
        if (i == 0) b = ra;
        else if (i < 8) b = PAT[7-i];
        if (!good && i == 1) b = 1'b1;
      end else begin
        if (i == 1) b = swb;
        else if (i == 2) b = ra;
      end
      send_bit(b, i);
    end
  endtask

  task automatic acquire();
    send_frame(1, 1, 1, 0);
    send_frame(0, 1, 1, 0);
    send_frame(1, 1, 1, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0 expected 1 (completion)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk("R1 lof", lof, 1);
    chk("R1 lof_irq", lof_irq, 0);
    chk("R1 fec", fec, 0);
    chk("R1 rai", rai, 0);
    chk("R10 ais_on", ais_on, 1);

    acquire();
    chk("R2 lof before bit 8", l6, 1);
    chk("R2 lof after bit 8", l7, 0);
    chk("R12 bit_pos at frame end", bit_pos, 0);

    fs_cnt = 0;
    send_frame(0, 1, 1, 1);
    chk("R9 rai set", rai, 1);
    send_frame(1, 1, 1, 0);
    send_frame(0, 1, 1, 0);
    chk("R9 rai cleared", rai, 0);
    send_frame(1, 1, 1, 0);
    chk("R12 frame_start count", fs_cnt, 4);
    chk("R12 bit_pos", bit_pos, 0);

    for (int four = 0; four < 2; four++)
      for (int off = 0; off < 2; off++)
        for (int kind = 0; kind < 2; kind++) begin
          int lost_at, exp_at, irq0;
          do_reset();
          thr_four = four[0]; sw_chk_off = off[0];
          acquire();
          irq0 = irq_cnt;
          lost_at = 0;
          for (int k = 1; k <= 5 && lost_at == 0; k++) begin
            if (kind == 0) begin
              send_frame(0, 1, 1, 0);
              send_frame(1, 0, 1, 0);
            end else begin
              send_frame(0, 1, 0, 0);
              send_frame(1, 1, 1, 0);
            end
            if (lof) lost_at = k;
          end
          exp_at = (kind == 1 && off == 1) ? 0 : (four == 1 ? 4 : 3);
          if (kind == 0) chk("R4 loss point", lost_at, exp_at);
          else if (off == 1) chk("R6 no loss", lost_at, exp_at);
          else chk("R5 loss point", lost_at, exp_at);
          chk("R7 irq count", irq_cnt - irq0, exp_at == 0 ? 0 : 1);
          chk("R8 fec count", fec, kind == 0 ? exp_at : 0);
          if (lost_at != 0) begin
            int f0;
            chk("R10 ais_on out of sync", ais_on, 1);
            ais_dis = 1; #1;
            chk("R10 ais_on disabled", ais_on, 0);
            ais_dis = 0;
            f0 = fec;
            send_frame(0, 1, 1, 1);
            send_frame(1, 0, 1, 0);
            send_frame(0, 1, 1, 1);
            chk("R8 fec frozen", fec, f0);
            chk("R9 rai frozen", rai, 0);
          end
        end
    thr_four = 0; sw_chk_off = 0;

    do_reset();
    send_frame(1, 1, 1, 0);
    send_frame(0, 1, 0, 0);
    send_frame(1, 1, 1, 0);
    send_frame(0, 1, 1, 0);
    send_frame(1, 1, 1, 0);
    chk("R3 frame n+2 skipped", lof, 1);
    send_frame(0, 1, 1, 0);
    send_frame(1, 1, 1, 0);
    chk("R3 sync after skip", l7, 0);
    chk("R3 not before bit 8", l6, 1);

    do_reset();
    send_frame(1, 1, 1, 0);
    send_frame(0, 1, 1, 0);
    send_frame(1, 0, 1, 0);
    send_frame(0, 1, 1, 0);
    send_frame(1, 1, 1, 0);
    send_frame(0, 1, 1, 0);
    chk("R3 still hunting", lof, 1);
    send_frame(1, 1, 1, 0);
    chk("R3 sync after n+2 failure", l7, 0);

    do_reset();
    acquire();
    send_frame(0, 1, 1, 0);
    @(negedge clk);
    force_resync = 1;
    @(negedge clk);
    force_resync = 0;
    chk("R11 lof after force", lof, 1);
    chk("R7 irq on force", lof_irq, 1);
    @(negedge clk);
    chk("R7 irq one cycle", lof_irq, 0);
    send_frame(1, 1, 1, 0);
    send_frame(0, 1, 1, 0);
    send_frame(1, 1, 1, 0);
    chk("R11 resync before bit 8", l6, 1);
    chk("R11 resync", l7, 0);

    do_reset();
    thr_four = 1;
    acquire();
    for (int r = 0; r < 6; r++) begin
      for (int j = 0; j < 3; j++) begin
        send_frame(0, 1, 1, 0);
        send_frame(1, 0, 1, 0);
      end
      send_frame(0, 1, 1, 0);
      send_frame(1, 1, 1, 0);
    end
    chk("R4 four-threshold holds", lof, 0);
    chk("R8 saturation", fec, 15);
    @(negedge clk);
    fec_clr = 1;
    @(negedge clk);
    fec_clr = 0;
    chk("R8 clear", fec, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule